// File: doc/BRIEF.md
# Video memory port with longword write cache

This block gives a processor with an 8-bit register bus access to a 128 KB video memory. The memory sits behind a 32-bit word port that has a byte enable per lane. Two address pointers, numbered 0 and 1, are each tied to a data register of their own. Every data-register access works at the address held in that register's pointer, and the pointer then steps forward by a programmable amount. A control register selects which pointer the three address registers reach. A six-bit window selector in the same control register maps two effect registers into the top of the register map.

The effect control register holds two enables. With fill enabled, every data-register read also stores the fetched byte in a 32-bit cache. With cached writing enabled, a data-register write ignores the processor's byte and stores all four cache bytes to an aligned longword in a single memory access.

Software copies memory fast with a repeating pattern. It reads four bytes through one pointer stepping by 1, then writes once through the other pointer stepping by 4. Filling a region works the same way, with the cache loaded once at the start.

Top module: `vram_cache_port`

## Requirements
- R1: After reset, both pointers, both increment codes, the control register, the effect enables, the effect multiplier byte and the cache are zero. The read data is 0 and the memory port has no strobe.
- R2: Register map: 0 pointer bits [7:0], 1 bits [15:8], 2 high register {increment code[7:4], 000, bit 16}, 3 data register of pointer 0, 4 data register of pointer 1, 5 control {0, window select[6:1], pointer select[0]}. Control bit 0 picks the pointer that registers 0 to 2 write and read back.
- R3: An increment code of 0 leaves the pointer unchanged. A code k from 1 to 15 advances it by 2^(k-1) after each data-register access, so code 1 steps 1 and code 3 steps 4.
- R4: A data-register read returns the memory byte at the pointer address on the cycle after the read strobe. The pointer then advances modulo 2^17, and the memory port receives exactly one read request.
- R5: With cached writing off, a data-register write stores the processor byte only in lane address[1:0] of word address[16:2], with one byte enable set.
- R6: Registers 6 (effect control, enables at bits 6 and 5) and 7 (multiplier byte) are reachable only while the window select equals 2. Otherwise writes to them are ignored and they read 0.
- R7: With fill enabled (bit 5), each data-register read stores the fetched byte into cache lane address[1:0] of the read pointer.
- R8: With cached writing enabled (bit 6), a data-register write stores all four cache bytes to word address[16:2] with all byte enables set. The processor byte is ignored and the pointer advances by its step.
- R9: A cached write in the cycle right after a filling read includes that read's byte.
- R10: Writing 0 to effect control restores plain byte writes and stops cache filling. A later cached write stores the cache as it was last filled.
- R11: Writing 0 to the multiplier register leaves the cache contents unchanged.
- R12: A loop of four reads on a step-1 pointer followed by one cached write on a step-4 pointer copies memory longword by longword. Unaligned source and target addresses follow R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Register read strobe, one cycle |
| cpu_wr | input | 1 | Register write strobe, one cycle; wins over cpu_rd |
| cpu_addr | input | 3 | Register number |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after cpu_rd |
| mem_re | output | 1 | Memory word read request |
| mem_we | output | 1 | Memory word write request |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 4 | Byte enables, lane 0 is bits [7:0] |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_re |

## Verification
Two functions can land in the same cycle. The cache update from the previous read's returning byte can coincide with a cached write that must already contain that byte. The bench provokes this by running each copy loop with strobes on consecutive cycles, so the fourth read is always followed at once by the flush. It judges the result by comparing the whole bench memory with a byte-wise reference. The reference is rebuilt from the lane rule for aligned and unaligned sources and targets.

// File: rtl/vram_cache_port.sv
module vram_cache_port #(
  parameter logic [5:0] WIN_SEL = 6'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [2:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        mem_re,
  output logic        mem_we,
  output logic [14:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int AW = 17;
  localparam logic [2:0] R_LO = 3'd0, R_MID = 3'd1, R_HI = 3'd2, R_D0 = 3'd3,
                         R_D1 = 3'd4, R_CTL = 3'd5, R_FXC = 3'd6, R_FXM = 3'd7;

  logic [AW-1:0] ptr [2];
  logic [3:0]    inc [2];
  logic [6:0]    ctrl;
  logic [1:0]    fx;
  logic [7:0]    mult;
  logic [31:0]   cache, cache_fwd;
  logic          fill_pend, rd_mem_q;
  logic [1:0]    fill_lane, rd_lane;
  logic [7:0]    reg_q, reg_val, rd_byte;
  logic [AW-1:0] step;

  wire rd_go  = cpu_rd & ~cpu_wr;
  wire is_dp  = (cpu_addr == R_D0) | (cpu_addr == R_D1);
  wire dp     = (cpu_addr == R_D1);
  wire sel    = ctrl[0];
  wire win    = (ctrl[6:1] == WIN_SEL);
  wire cwr_en = fx[1];
  wire fill_en = fx[0];
  wire [AW-1:0] cur = ptr[dp];
  wire [3:0] cinc = inc[dp];

  assign step    = (cinc == 4'd0) ? '0 : (AW'(1) << (cinc - 4'd1));
  assign rd_byte = 8'(mem_rdata >> {rd_lane, 3'b000});

  always_comb begin
    cache_fwd = cache;
    if (fill_pend) cache_fwd[8*fill_lane +: 8] = rd_byte;
  end

  assign mem_re    = rd_go & is_dp;
  assign mem_we    = cpu_wr & is_dp;
  assign mem_addr  = cur[AW-1:2];
  assign mem_be    = cwr_en ? 4'hF : (4'b0001 << cur[1:0]);
  assign mem_wdata = cwr_en ? cache_fwd : {4{cpu_wdata}};
  assign cpu_rdata = rd_mem_q ? rd_byte : reg_q;

  always_comb begin
    case (cpu_addr)
      R_LO:    reg_val = ptr[sel][7:0];
      R_MID:   reg_val = ptr[sel][15:8];
      R_HI:    reg_val = {inc[sel], 3'b000, ptr[sel][16]};
      R_CTL:   reg_val = {1'b0, ctrl};
      R_FXC:   reg_val = win ? {1'b0, fx, 5'b00000} : 8'h00;
      R_FXM:   reg_val = win ? mult : 8'h00;
      default: reg_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr[0] <= '0; ptr[1] <= '0; inc[0] <= '0; inc[1] <= '0;
      ctrl <= '0; fx <= '0; mult <= '0; cache <= '0;
      fill_pend <= 1'b0; fill_lane <= '0; rd_mem_q <= 1'b0; rd_lane <= '0;
      reg_q <= '0;
    end else begin
      rd_mem_q  <= mem_re;
      rd_lane   <= cur[1:0];
      fill_pend <= mem_re & fill_en;
      fill_lane <= cur[1:0];
      if (fill_pend) cache <= cache_fwd;
      if (rd_go) reg_q <= reg_val;
      if ((rd_go | cpu_wr) & is_dp) ptr[dp] <= cur + step;
      if (cpu_wr) begin
        case (cpu_addr)
          R_LO:  ptr[sel][7:0]  <= cpu_wdata;
          R_MID: ptr[sel][15:8] <= cpu_wdata;
          R_HI:  begin ptr[sel][16] <= cpu_wdata[0]; inc[sel] <= cpu_wdata[7:4]; end
          R_CTL: ctrl <= cpu_wdata[6:0];
          R_FXC: if (win) fx <= cpu_wdata[6:5];
          R_FXM: if (win) mult <= cpu_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

module vram_cache_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [2:0]  cpu_addr,
  input logic        mem_re,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [7:0]  cpu_rdata,
  input logic        cwr_en,
  input logic        fill_pend,
  input logic [1:0]  fill_lane,
  input logic [31:0] cache
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> !mem_re && !mem_we); // R4
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R4
  AST_DATA_READ_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && (cpu_addr == 3'd3 || cpu_addr == 3'd4)) |-> mem_re); // R4
  AST_PLAIN_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !cwr_en) |-> $countones(mem_be) == 1); // R5
  AST_CACHED_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cwr_en) |-> mem_be == 4'hF); // R8
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pend |=> 8'(cache >> {$past(fill_lane), 3'b000}) == $past(cpu_rdata)); // R7
endmodule

bind vram_cache_port vram_cache_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .cpu_rdata(cpu_rdata),
  .cwr_en(fx[1]), .fill_pend(fill_pend), .fill_lane(fill_lane), .cache(cache));

// File: tb/test_vram_cache_port.sv
module test_vram_cache_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic mem_re, mem_we;
  logic [14:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] bmem [1024];
  logic [7:0] refb [4096];
  logic [7:0] cm [4];
  logic [5:0] dc = 6'd0;

  always #5 clk = ~clk;

  vram_cache_port i_vram_cache_port (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 1024; w++)
        bmem[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      mem_rdata <= '0;
    end else begin
      if (mem_re) mem_rdata <= bmem[mem_addr[9:0]];
      if (mem_we)
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) bmem[mem_addr[9:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic set_ptr(input bit p, input int a, input logic [3:0] code);
    wr(3'd5, {1'b0, dc, p});
    wr(3'd0, 8'(a));
    wr(3'd1, 8'(a >> 8));
    wr(3'd2, {code, 3'b000, 1'(a >> 16)});
  endtask

  task automatic cmp_mem(input string r);
    int bad = -1;
    for (int a = 0; a < 4096; a++)
      if (bad < 0 && bmem[a >> 2][8*(a & 3) +: 8] !== refb[a]) bad = a;
    if (bad < 0) chk(r, 0, 0);
    else chk({r, " byte mismatch"}, int'(bmem[bad >> 2][8*(bad & 3) +: 8]), int'(refb[bad]));
  endtask

  task automatic copy_run(input string r, input int src, input int dst, input int n);
    logic [7:0] v;
    int t;
    set_ptr(1'b1, src, 4'd1);
    set_ptr(1'b0, dst, 4'd3);
    wr(3'd6, 8'h60);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 4; j++) begin
        rd(3'd4, v);
        cm[(src + 4*k + j) & 3] = refb[(src + 4*k + j) & 12'hFFF];
      end
      wr(3'd3, 8'hAB);
      t = (dst + 4*k) & 32'hFFC;
      for (int l = 0; l < 4; l++) refb[t + l] = cm[l];
    end
    cmp_mem(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s, b;
    for (int a = 0; a < 4096; a++) refb[a] = pat(a);
    repeat (3) @(negedge clk);
    chk("R1 rdata", int'(cpu_rdata), 0);
    chk("R1 strobes", int'({mem_re, mem_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      if (r == 3 || r == 4) continue;
      rd(3'(r), v);
      chk($sformatf("R1 reg %0d", r), int'(v), 0);
    end

    // R2 pointer select and readback
    set_ptr(1'b1, 17'h1A5C3, 4'd2);
    rd(3'd0, v); chk("R2 p1 lo", int'(v), 8'hC3);
    rd(3'd1, v); chk("R2 p1 mid", int'(v), 8'hA5);
    rd(3'd2, v); chk("R2 p1 hi", int'(v), 8'h21);
    wr(3'd5, 8'h00);
    rd(3'd0, v); chk("R2 p0 lo untouched", int'(v), 0);
    rd(3'd5, v); chk("R2 ctrl", int'(v), 0);

    // R3 / R4 increment sweep
    for (int code = 0; code < 5; code++) begin
      s = (code == 0) ? 0 : (1 << (code - 1));
      b = 17'h300 + code;
      set_ptr(1'b0, b, 4'(code));
      for (int k = 0; k < 6; k++) begin
        rd(3'd3, v);
        chk($sformatf("R4 read code %0d k %0d", code, k), int'(v), int'(refb[(b + k*s) & 12'hFFF]));
      end
      rd(3'd0, v); chk($sformatf("R3 step code %0d", code), int'(v), (b + 6*s) & 8'hFF);
      rd(3'd1, v); chk($sformatf("R3 step mid code %0d", code), int'(v), ((b + 6*s) >> 8) & 8'hFF);
    end
    // R4 wrap modulo 2^17
    set_ptr(1'b0, 17'h1FFFF, 4'd1);
    rd(3'd3, v); chk("R4 top byte", int'(v), int'(refb[12'hFFF]));
    rd(3'd3, v); chk("R4 wrapped byte", int'(v), int'(refb[0]));
    rd(3'd0, v); chk("R4 wrap lo", int'(v), 1);
    rd(3'd2, v); chk("R4 wrap hi", int'(v), 8'h10);

    // R5 plain writes, all lanes
    set_ptr(1'b0, 17'h801, 4'd1);
    for (int k = 0; k < 8; k++) begin
      wr(3'd3, 8'(8'hC0 + k));
      refb[12'h801 + k] = 8'(8'hC0 + k);
    end
    cmp_mem("R5 plain writes");
    set_ptr(1'b1, 17'h803, 4'd1);
    rd(3'd4, v); chk("R5 readback", int'(v), 8'hC2);

    // R6 window
    dc = 6'd1;
    wr(3'd5, {1'b0, dc, 1'b0});
    wr(3'd6, 8'h60);
    rd(3'd6, v); chk("R6 closed window reads 0", int'(v), 0);
    wr(3'd7, 8'h33);
    dc = 6'd2;
    wr(3'd5, {1'b0, dc, 1'b0});
    rd(3'd6, v); chk("R6 closed write ignored", int'(v), 0);
    rd(3'd7, v); chk("R6 closed mult ignored", int'(v), 0);
    wr(3'd6, 8'hFF);
    rd(3'd6, v); chk("R6 fx enables", int'(v), 8'h60);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h33);
    rd(3'd7, v); chk("R6 mult", int'(v), 8'h33);

    // R7 R8 R9 R12 copy loops, back to back
    copy_run("R12 R9 aligned copy", 17'h100, 17'h400, 16);
    copy_run("R7 R8 unaligned src", 17'h201, 17'h500, 8);
    copy_run("R8 unaligned dst", 17'h2A3, 17'h602, 8);
    copy_run("R12 wrap src", 17'h1FFFE, 17'h700, 3);

    // R11 multiplier write leaves cache alone
    set_ptr(1'b1, 17'h140, 4'd1);
    set_ptr(1'b0, 17'h900, 4'd3);
    wr(3'd6, 8'h60);
    for (int j = 0; j < 4; j++) begin
      rd(3'd4, v);
      cm[j] = refb[12'h140 + j];
    end
    wr(3'd7, 8'h00);
    wr(3'd3, 8'h11);
    for (int l = 0; l < 4; l++) refb[12'h900 + l] = cm[l];
    cmp_mem("R11 mult write keeps cache");

    // R10 fx off: plain write, no filling
    wr(3'd6, 8'h00);
    wr(3'd3, 8'h77);
    refb[12'h904] = 8'h77;
    cmp_mem("R10 plain after fx off");
    for (int j = 0; j < 4; j++) begin
      rd(3'd4, v);
      chk("R10 plain read", int'(v), int'(refb[12'h144 + j]));
    end
    set_ptr(1'b0, 17'hA00, 4'd3);
    wr(3'd6, 8'h40);
    wr(3'd3, 8'h22);
    for (int l = 0; l < 4; l++) refb[12'hA00 + l] = cm[l];
    cmp_mem("R10 no fill while off");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule